// File: doc/BRIEF.md
# MOESI Snooping Line Controller

This block keeps the coherence state of every line of one private, direct-mapped cache that sits on a shared snooping bus next to other caches. Each line carries a tag and one of five states: Modified, Owned, Exclusive, Shared or Invalid. The processor side presents read and write requests and gets hit, miss and stall indications. The bus side issues its own read, read-for-ownership, invalidate and writeback transactions. It also watches the transactions of the other caches and answers them with a shared indication and a supply-data strobe.

A request is held by the processor until the cycle in which `hit_o` is high. A lookup that cannot complete starts a short sequence of bus transactions, one at a time. The optional writeback of a dirty victim comes first, then a fill or an upgrade. After that the lookup is retried and hits. Each bus transaction completes in the cycle its grant is high. Data storage, arbitration and memory are outside the block; data movement appears only as the supply strobe and the bus operations.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address reports `miss_o` and no hit.
- R2: A read whose index holds a valid line with a matching tag reports `hit_o` in the lookup cycle, with `stall_o` and `bus_req_o` low, and leaves the state unchanged.
- R3: A read miss raises `miss_o` in the lookup cycle. It then requests a bus read (`bus_op_o` = 1) at the line-aligned address: offset bits zero, index in the bits just above the offset, tag on top. In the grant cycle the line is filled to Exclusive if `bus_shared_i` is low and to Shared if it is high, and the retried lookup hits one cycle later.
- R4: A write miss requests a read-for-ownership (`bus_op_o` = 2) at the line-aligned address and fills the line to Modified.
- R5: A write hit on an Exclusive line completes at once and makes the line Modified without any bus traffic; a write hit on Modified also completes at once.
- R6: A write hit on a Shared or Owned line stalls and requests a bus invalidate (`bus_op_o` = 3) of that line; on its grant the line becomes Modified and the retried write hits.
- R7: A snooped read (`snp_op_i` = 1) that matches a valid line raises `snp_shared_o`. Modified becomes Owned and Exclusive becomes Shared. Modified and Owned raise `snp_supply_o`; Exclusive and Shared do not.
- R8: A snooped read-for-ownership or invalidate (`snp_op_i` = 2 or 3) that matches a valid line makes it Invalid without raising `snp_shared_o`. A Modified or Owned line raises `snp_supply_o` in that cycle.
- R9: A miss whose victim is Modified or Owned first requests a writeback (`bus_op_o` = 4) at the victim's own line address and issues the fill one cycle after its grant. A victim in Exclusive or Shared is dropped with no bus traffic.
- R10: In a cycle with `snp_valid_i` high, the processor lookup neither hits nor misses and the request stays stalled, so the snooped transition applies first.
- R11: A snooped writeback (`snp_op_i` = 4), or a snoop whose tag differs from the stored one, gives no response and changes no state.
- R12: If a snoop invalidates the line while its upgrade or its victim writeback is still waiting for grant, the pending request is withdrawn in the next cycle. A withdrawn upgrade returns to lookup, where the write now misses. A withdrawn writeback goes straight to the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present, held until hit |
| req_write_i | input | 1 | Request is a write |
| req_addr_i | input | ADDR_W | Request byte address |
| hit_o | output | 1 | Request completes this cycle |
| miss_o | output | 1 | Lookup found no matching valid line |
| stall_o | output | 1 | Request present and not completing |
| bus_req_o | output | 1 | Own bus transaction requested |
| bus_op_o | output | 3 | Own transaction: 1 read, 2 read-for-ownership, 3 invalidate, 4 writeback |
| bus_addr_o | output | ADDR_W | Line-aligned address of own transaction |
| bus_gnt_i | input | 1 | Own transaction granted and completed this cycle |
| bus_shared_i | input | 1 | Another cache holds the line being read |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_op_i | input | 3 | Snooped transaction, same encoding as bus_op_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_shared_o | output | 1 | This cache holds the snooped line (reads) |
| snp_supply_o | output | 1 | This cache provides the line data |

## Verification
Lookup results (`hit_o`, `miss_o`, `stall_o`) and snoop responses are combinational and due in the same cycle as the stimulus. The state change they cause takes effect at the next rising edge. The first bus request follows one cycle after the lookup. The next bus step, or the retried hit, follows one cycle after each grant. The bench drives every input just after a falling edge and samples 1 ns later, well before the rising edge, stepping exactly one cycle per stage of this chain. A state-tracking model in the bench predicts each sample from R1 to R12.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RD   = 3'd1,
    OP_RDX  = 3'd2,
    OP_INV  = 3'd3,
    OP_WB   = 3'd4
  } bus_op_e;

  function automatic logic st_dirty(line_st_e s);
    return (s == ST_M) || (s == ST_O);
  endfunction
endpackage

// File: rtl/moesi_tag_array.sv
module moesi_tag_array
  import moesi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] a_idx_i,
  output logic [TAG_W-1:0] a_tag_o,
  output line_st_e         a_st_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic [TAG_W-1:0] b_tag_o,
  output line_st_e         b_st_o,
  input  logic             snp_we_i,
  input  line_st_e         snp_st_i,
  input  logic             own_we_i,
  input  logic             own_tag_we_i,
  input  logic [TAG_W-1:0] own_tag_i,
  input  line_st_e         own_st_i
);
  localparam int LINES = 1 << IDX_W;

  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  // snoop write wins; the bus never grants own and snooped traffic together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snp_we_i && (b_idx_i == IDX_W'(i))) begin
          st_q[i] <= snp_st_i;
        end else if (own_we_i && (a_idx_i == IDX_W'(i))) begin
          st_q[i] <= own_st_i;
          if (own_tag_we_i) tag_q[i] <= own_tag_i;
        end
      end
    end
  end

  assign a_tag_o = tag_q[a_idx_i];
  assign a_st_o  = st_q[a_idx_i];
  assign b_tag_o = tag_q[b_idx_i];
  assign b_st_o  = st_q[b_idx_i];
endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
  import moesi_pkg::*;
(
  input  logic     valid_i,
  input  bus_op_e  op_i,
  input  logic     match_i,
  input  line_st_e st_i,
  output logic     we_o,
  output line_st_e nxt_o,
  output logic     shared_o,
  output logic     supply_o
);
  always_comb begin
    we_o     = 1'b0;
    nxt_o    = st_i;
    shared_o = 1'b0;
    supply_o = 1'b0;
    if (valid_i && match_i) begin
      unique case (op_i)
        OP_RD: begin
          shared_o = 1'b1;
          supply_o = st_dirty(st_i);
          if (st_i == ST_M) begin
            we_o  = 1'b1;
            nxt_o = ST_O;
          end else if (st_i == ST_E) begin
            we_o  = 1'b1;
            nxt_o = ST_S;
          end
        end
        OP_RDX, OP_INV: begin
          supply_o = st_dirty(st_i);
          we_o     = 1'b1;
          nxt_o    = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              stall_o,
  output logic              bus_req_o,
  output logic [2:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL, F_UPG} fsm_e;

  fsm_e fsm_q, fsm_d;

  logic [IDX_W-1:0] req_idx, snp_idx;
  logic [TAG_W-1:0] req_tag, snp_tag, a_tag, b_tag;
  line_st_e         a_st, b_st, snp_nxt, own_st;
  logic             a_match, snp_match, snp_we;
  logic             own_we, own_tag_we;
  bus_op_e          op_d;
  logic             unused_off;

  assign req_idx = req_addr_i[OFF_W +: IDX_W];
  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign snp_idx = snp_addr_i[OFF_W +: IDX_W];
  assign snp_tag = snp_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_off = ^{req_addr_i[OFF_W-1:0], snp_addr_i[OFF_W-1:0]};

  moesi_tag_array #(
    .IDX_W(IDX_W),
    .TAG_W(TAG_W)
  ) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .a_idx_i      (req_idx),
    .a_tag_o      (a_tag),
    .a_st_o       (a_st),
    .b_idx_i      (snp_idx),
    .b_tag_o      (b_tag),
    .b_st_o       (b_st),
    .snp_we_i     (snp_we),
    .snp_st_i     (snp_nxt),
    .own_we_i     (own_we),
    .own_tag_we_i (own_tag_we),
    .own_tag_i    (req_tag),
    .own_st_i     (own_st)
  );

  assign snp_match = (b_st != ST_I) && (b_tag == snp_tag);

  moesi_snoop_resp u_snoop (
    .valid_i  (snp_valid_i),
    .op_i     (bus_op_e'(snp_op_i)),
    .match_i  (snp_match),
    .st_i     (b_st),
    .we_o     (snp_we),
    .nxt_o    (snp_nxt),
    .shared_o (snp_shared_o),
    .supply_o (snp_supply_o)
  );

  assign a_match = (a_st != ST_I) && (a_tag == req_tag);

  always_comb begin
    fsm_d      = fsm_q;
    hit_o      = 1'b0;
    miss_o     = 1'b0;
    bus_req_o  = 1'b0;
    op_d       = OP_NONE;
    bus_addr_o = {req_tag, req_idx, {OFF_W{1'b0}}};
    own_we     = 1'b0;
    own_tag_we = 1'b0;
    own_st     = ST_I;
    unique case (fsm_q)
      F_IDLE: begin
        // a snoop in flight goes first
        if (req_valid_i && !snp_valid_i) begin
          if (a_match) begin
            if (!req_write_i || a_st == ST_M) begin
              hit_o = 1'b1;
            end else if (a_st == ST_E) begin
              hit_o  = 1'b1;
              own_we = 1'b1;
              own_st = ST_M;
            end else begin
              fsm_d = F_UPG;
            end
          end else begin
            miss_o = 1'b1;
            fsm_d  = st_dirty(a_st) ? F_WB : F_FILL;
          end
        end
      end
      F_WB: begin
        if (!st_dirty(a_st)) begin
          fsm_d = F_FILL;
        end else begin
          bus_req_o  = 1'b1;
          op_d       = OP_WB;
          bus_addr_o = {a_tag, req_idx, {OFF_W{1'b0}}};
          if (bus_gnt_i) begin
            own_we = 1'b1;
            own_st = ST_I;
            fsm_d  = F_FILL;
          end
        end
      end
      F_FILL: begin
        bus_req_o = 1'b1;
        op_d      = req_write_i ? OP_RDX : OP_RD;
        if (bus_gnt_i) begin
          own_we     = 1'b1;
          own_tag_we = 1'b1;
          own_st     = req_write_i ? ST_M : (bus_shared_i ? ST_S : ST_E);
          fsm_d      = F_IDLE;
        end
      end
      F_UPG: begin
        if (!(a_match && (a_st == ST_S || a_st == ST_O))) begin
          fsm_d = F_IDLE;
        end else begin
          bus_req_o = 1'b1;
          op_d      = OP_INV;
          if (bus_gnt_i) begin
            own_we = 1'b1;
            own_st = ST_M;
            fsm_d  = F_IDLE;
          end
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  assign bus_op_o = op_d;
  assign stall_o  = req_valid_i && !hit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fsm_q <= F_IDLE;
    else         fsm_q <= fsm_d;
  end
endmodule

module moesi_line_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              hit_o,
  input logic              miss_o,
  input logic              stall_o,
  input logic              bus_req_o,
  input logic [2:0]        bus_op_o,
  input logic              bus_gnt_i,
  input logic              snp_valid_i,
  input logic [2:0]        snp_op_i,
  input logic              snp_shared_o,
  input logic              snp_supply_o
);
  a_r2_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (!bus_req_o && !stall_o && !miss_o));

  a_r10_snoop_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> (!hit_o && !miss_o));

  a_r7_supply_is_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_op_i == 3'd1 && snp_supply_o) |-> snp_shared_o);

  a_r8_kill_not_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && (snp_op_i == 3'd2 || snp_op_i == 3'd3)) |-> !snp_shared_o);

  a_r11_wb_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_op_i == 3'd4) |-> (!snp_shared_o && !snp_supply_o));

  a_r9_wb_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_op_o == 3'd4)
      |=> (bus_req_o && (bus_op_o == 3'd1 || bus_op_o == 3'd2)));

  a_r4_owned_fill_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_op_o == 3'd2)
      |=> (!(req_valid_i && req_write_i && $stable(req_addr_i) && !snp_valid_i) || hit_o));
endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/moesi_line_ctrl_tb.sv
module moesi_line_ctrl_tb_top;
  localparam int S_I = 0, S_S = 1, S_E = 2, S_O = 3, S_M = 4;
  localparam int OP_RD = 1, OP_RDX = 2, OP_INV = 3, OP_WB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        hit_o, miss_o, stall_o, bus_req_o;
  logic [2:0]  bus_op_o;
  logic [15:0] bus_addr_o;
  logic        bus_gnt = 1'b0, bus_shared = 1'b0;
  logic        snp_valid = 1'b0;
  logic [2:0]  snp_op = '0;
  logic [15:0] snp_addr = '0;
  logic        snp_shared_o, snp_supply_o;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  int mst [4];
  logic [9:0] mtag [4];

  always #5 clk = ~clk;

  moesi_line_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .hit_o(hit_o), .miss_o(miss_o), .stall_o(stall_o),
    .bus_req_o(bus_req_o), .bus_op_o(bus_op_o), .bus_addr_o(bus_addr_o),
    .bus_gnt_i(bus_gnt), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared_o), .snp_supply_o(snp_supply_o)
  );

  task automatic check(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int tg, input int ix);
    return {10'(tg), 2'(ix), 4'h5};
  endfunction

  function automatic bit dirty(input int s);
    return (s == S_M) || (s == S_O);
  endfunction

  task automatic proc_access(input bit w, input logic [15:0] addr, input bit shr, input string rq);
    int ix;
    logic [9:0] tg;
    logic [15:0] line;
    bit hm;
    ix   = int'(addr[5:4]);
    tg   = addr[15:6];
    line = {addr[15:4], 4'h0};
    hm   = (mst[ix] != S_I) && (mtag[ix] == tg);
    @(negedge clk); req_valid = 1'b1; req_write = w; req_addr = addr; #1;
    if (hm && (!w || mst[ix] == S_M || mst[ix] == S_E)) begin
      check(rq, "hit_o", int'(hit_o), 1);
      check(rq, "bus_req_o", int'(bus_req_o), 0);
      check(rq, "stall_o", int'(stall_o), 0);
      if (w) mst[ix] = S_M;
    end else begin
      check(rq, "hit_o", int'(hit_o), 0);
      check(rq, "miss_o", int'(miss_o), hm ? 0 : 1);
      check(rq, "stall_o", int'(stall_o), 1);
      if (hm) begin
        @(negedge clk); #1;
        check(rq, "bus_req_o", int'(bus_req_o), 1);
        check(rq, "bus_op_o", int'(bus_op_o), OP_INV);
        check(rq, "bus_addr_o", int'(bus_addr_o), int'(line));
        bus_gnt = 1'b1;
      end else begin
        if (dirty(mst[ix])) begin
          @(negedge clk); #1;
          check(rq, "bus_req_o wb", int'(bus_req_o), 1);
          check(rq, "bus_op_o wb", int'(bus_op_o), OP_WB);
          check(rq, "bus_addr_o wb", int'(bus_addr_o), int'({mtag[ix], 2'(ix), 4'h0}));
          bus_gnt = 1'b1;
          @(negedge clk); bus_gnt = 1'b0; #1;
        end else begin
          @(negedge clk); #1;
        end
        check(rq, "bus_req_o fill", int'(bus_req_o), 1);
        check(rq, "bus_op_o fill", int'(bus_op_o), w ? OP_RDX : OP_RD);
        check(rq, "bus_addr_o fill", int'(bus_addr_o), int'(line));
        bus_gnt = 1'b1; bus_shared = shr;
        mtag[ix] = tg;
      end
      mst[ix] = w ? S_M : (shr ? S_S : S_E);
      @(negedge clk); bus_gnt = 1'b0; bus_shared = 1'b0; #1;
      check(rq, "hit_o retry", int'(hit_o), 1);
      check(rq, "bus_req_o retry", int'(bus_req_o), 0);
    end
    @(negedge clk); req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic snoop(input int op, input logic [15:0] addr, input string rq);
    int ix;
    bit m;
    ix = int'(addr[5:4]);
    m  = (mst[ix] != S_I) && (mtag[ix] == addr[15:6]);
    @(negedge clk); snp_valid = 1'b1; snp_op = 3'(op); snp_addr = addr; #1;
    check(rq, "snp_shared_o", int'(snp_shared_o), (m && op == OP_RD) ? 1 : 0);
    check(rq, "snp_supply_o", int'(snp_supply_o), (m && op != OP_WB && dirty(mst[ix])) ? 1 : 0);
    if (m) begin
      if (op == OP_RD && mst[ix] == S_M) mst[ix] = S_O;
      else if (op == OP_RD && mst[ix] == S_E) mst[ix] = S_S;
      else if (op == OP_RDX || op == OP_INV) mst[ix] = S_I;
    end
    @(negedge clk); snp_valid = 1'b0; snp_op = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R1 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b, c, d, e;
    for (int i = 0; i < 4; i++) begin mst[i] = S_I; mtag[i] = '0; end
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1", "hit_o", int'(hit_o), 0);
    check("R1", "miss_o", int'(miss_o), 0);
    check("R1", "stall_o", int'(stall_o), 0);
    check("R1", "bus_req_o", int'(bus_req_o), 0);
    check("R1", "bus_op_o", int'(bus_op_o), 0);

    for (int i = 0; i < 4; i++) begin
      a = mk(i * 3 + 1, i);
      b = mk(i * 3 + 101, i);
      c = mk(i * 3 + 201, i);
      proc_access(1'b0, a, 1'b0, "R1");
      proc_access(1'b0, a, 1'b0, "R2");
      snoop(OP_RD, a, "R7");
      proc_access(1'b1, a, 1'b0, "R6");
      snoop(OP_RD, a, "R7");
      proc_access(1'b0, a, 1'b0, "R2");
      snoop(OP_RD, a, "R7");
      proc_access(1'b1, a, 1'b0, "R6");
      snoop(OP_RDX, a, "R8");
      proc_access(1'b0, a, 1'b1, "R3");
      snoop(OP_RD, b, "R11");
      snoop(OP_WB, a, "R11");
      proc_access(1'b0, a, 1'b0, "R11");
      snoop(OP_INV, a, "R8");
      proc_access(1'b1, a, 1'b0, "R4");
      proc_access(1'b1, a, 1'b0, "R5");
      proc_access(1'b0, b, 1'b0, "R9");
      proc_access(1'b1, b, 1'b0, "R5");
      snoop(OP_RD, b, "R7");
      proc_access(1'b0, c, 1'b1, "R9");
      proc_access(1'b0, a, 1'b0, "R9");
      snoop(OP_RDX, a, "R8");
    end

    // R10: snoop and write hit on an Exclusive line in the same cycle
    d = mk(700, 1);
    proc_access(1'b0, d, 1'b0, "R3");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = d;
    snp_valid = 1'b1; snp_op = 3'(OP_RD); snp_addr = d; #1;
    check("R10", "hit_o", int'(hit_o), 0);
    check("R10", "miss_o", int'(miss_o), 0);
    check("R10", "stall_o", int'(stall_o), 1);
    check("R7", "snp_shared_o", int'(snp_shared_o), 1);
    check("R7", "snp_supply_o", int'(snp_supply_o), 0);
    mst[1] = S_S;
    @(negedge clk); snp_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    proc_access(1'b1, d, 1'b0, "R10");

    // R12: upgrade withdrawn by a snooped read-for-ownership
    snoop(OP_RD, d, "R7");
    @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_addr = d; #1;
    check("R6", "stall_o", int'(stall_o), 1);
    @(negedge clk); #1;
    check("R6", "bus_op_o", int'(bus_op_o), OP_INV);
    snp_valid = 1'b1; snp_op = 3'(OP_RDX); snp_addr = d; #1;
    check("R8", "snp_supply_o", int'(snp_supply_o), 1);
    mst[1] = S_I;
    @(negedge clk); snp_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0; #1;
    check("R12", "bus_req_o upgrade withdrawn", int'(bus_req_o), 0);
    proc_access(1'b1, d, 1'b0, "R12");

    // R12: victim writeback withdrawn by a snooped read-for-ownership
    e = mk(701, 1);
    @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_addr = e; #1;
    check("R9", "miss_o", int'(miss_o), 1);
    @(negedge clk); #1;
    check("R9", "bus_op_o", int'(bus_op_o), OP_WB);
    snp_valid = 1'b1; snp_op = 3'(OP_RDX); snp_addr = d; #1;
    check("R8", "snp_supply_o", int'(snp_supply_o), 1);
    @(negedge clk); snp_valid = 1'b0; #1;
    check("R12", "bus_req_o wb withdrawn", int'(bus_req_o), 0);
    @(negedge clk); #1;
    check("R12", "bus_req_o fill", int'(bus_req_o), 1);
    check("R12", "bus_op_o fill", int'(bus_op_o), OP_RD);
    check("R12", "bus_addr_o fill", int'(bus_addr_o), int'({e[15:4], 4'h0}));
    bus_gnt = 1'b1;
    mst[1] = S_E; mtag[1] = e[15:6];
    @(negedge clk); bus_gnt = 1'b0; #1;
    check("R3", "hit_o", int'(hit_o), 1);
    @(negedge clk); req_valid = 1'b0;
    proc_access(1'b1, e, 1'b0, "R5");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule